// File: doc/BRIEF.md
# Differential Clock Output Gating and Power-Down Controller

This block is the control logic beside a six-pair differential clock generator with one single-ended reference clock output. It decides, on every cycle of its control clock, which differential pairs may toggle, whether the reference output is driven at all, and whether it runs or sits low. The analog drivers consume its per-pair run controls and the reference enable and run controls. The PLL, oscillator and serial management engine stay outside.

The power-good input does two jobs. Its first high level marks start-up: at that point the block captures the address strap and the three-level spread strap, and it holds both until reset. Each later low level puts the outputs into power-down, and each high level brings them back. A pair runs only when power is good, the PLL reports lock, its register enable bit is set and its active-low enable pin is low. The reference output is high-impedance until start-up. After start-up it runs while power is good. In power-down it is driven low unless the wake-on-LAN bit asks it to keep running. Run controls change only while the gated clock is in its low phase, so no shortened pulse reaches a pin.

Top module: `clkout_pm_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it, every output (`dif_run`, `ref_oe`, `ref_run`, `smb_addr`, `spread_mode`) is zero.
- R2: The straps are captured exactly once, in the clock edge at which the synchronised power-good level is first seen high after reset. Later power-good rises and strap changes leave `smb_addr` and `spread_mode` unchanged.
- R3: `smb_addr` is 7'b1101000 when `addr_strap` was 0 at capture and 7'b1101010 when it was 1. The read/write bit is appended below it by the serial engine.
- R4: `spread_strap` code 2'b00 (pad low) gives `spread_mode` 2'b00 (no spread). 2'b01 (pad mid) gives 2'b01 (-0.25%). 2'b10 (pad high) gives 2'b10 (-0.5%). The unused code 2'b11 gives 2'b00.
- R5: While the synchronised power-good level is low, every bit of `dif_run` is 0 at the next permitted update, whatever the enable pins and bits are.
- R6: Bit i of `dif_run` becomes 1 only if power is good, `pll_locked` is 1, `oe_reg[i]` is 1 and the synchronised `oe_n[i]` is 0. Otherwise both legs of that pair are held low (`dif_run[i]` = 0).
- R7: `ref_oe` is 0 until start-up and 1 from start-up until reset. It rises three clock edges after `pwr_good` goes high.
- R8: After start-up, `ref_run` is 1 while power is good. During power-down it equals `wol_en`. Before start-up it is 0.
- R9: While `pll_locked` is 0, every pair is blocked (`dif_run` = 0 at the next permitted update).
- R10: `dif_run` changes only at a clock edge where `dif_clk_low` is 1. While it is 0, `dif_run` holds.
- R11: `pwr_good` and `oe_n` pass through a two-flop synchroniser. A change on `oe_n[i]` reaches `dif_run[i]` at the third clock edge after it is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good | input | 1 | Asynchronous power-good; low means power-down |
| oe_n | input | 6 | Asynchronous per-pair enable pins, active low |
| oe_reg | input | 6 | Per-pair register enable bits, active high |
| wol_en | input | 1 | Keep the reference output running in power-down |
| addr_strap | input | 1 | Decoded address strap level |
| spread_strap | input | 2 | Three-level spread strap code from the pad detector |
| pll_locked | input | 1 | PLL lock indication, synchronous to clk |
| dif_clk_low | input | 1 | Gated clock is in its low phase; run controls may change |
| dif_run | output | 6 | Per-pair run control; 0 drives both legs low |
| ref_oe | output | 1 | Reference output driven (0 = high-impedance) |
| ref_run | output | 1 | Reference output toggles (0 = held low when driven) |
| smb_addr | output | 7 | Latched 7-bit serial management address |
| spread_mode | output | 2 | Latched spread selection |

## Verification
The hardest situation to reach is a second start-up attempt with different strap levels. Here the block must show that it ignores them, and that only reset re-arms capture. The stimulus powers up once, changes the straps, cycles power-good low and high, and compares the address and spread outputs against the values first captured. Then it resets and starts up again with each strap code. A second hard case is a gating request that arrives while `dif_clk_low` is held at 0. The bench holds that phase for several cycles after disabling a pair, then releases it and watches for the single edge at which the pair stops.

// File: rtl/clkpm_pkg.sv
package clkpm_pkg;

    localparam int NUM_PAIRS  = 6;
    localparam int ADDR_W     = 7;
    localparam int SYNC_DEPTH = 2;

    typedef enum logic [1:0] {
        SPR_OFF  = 2'b00,
        SPR_QTR  = 2'b01,
        SPR_HALF = 2'b10
    } spread_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        spread_e           spread;
    } strap_cfg_t;

    localparam logic [ADDR_W-1:0] ADDR_BASE = 7'b1101000;

    // the address strap moves bit 1 of the base address
    function automatic logic [ADDR_W-1:0] addr_decode(input logic sel);
        return ADDR_BASE | {{(ADDR_W-2){1'b0}}, sel, 1'b0};
    endfunction

    function automatic spread_e spread_decode(input logic [1:0] code);
        case (code)
            2'b01:   return SPR_QTR;
            2'b10:   return SPR_HALF;
            default: return SPR_OFF;
        endcase
    endfunction

endpackage

// File: rtl/clkpm_sync.sv
module clkpm_sync #(
    parameter int W     = 1,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[DEPTH-1];
endmodule

// File: rtl/clkpm_strap_latch.sv
module clkpm_strap_latch
    import clkpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pg_sync,
    input  logic       addr_strap,
    input  logic [1:0] spread_strap,
    output logic       started,
    output strap_cfg_t cfg
);
    logic capture;
    assign capture = pg_sync && !started;

    always_ff @(posedge clk) begin
        if (rst) begin
            started <= 1'b0;
            cfg     <= '0;
        end else if (capture) begin
            started     <= 1'b1;
            cfg.addr    <= addr_decode(addr_strap);
            cfg.spread  <= spread_decode(spread_strap);
        end
    end
endmodule

// File: rtl/clkpm_pair_gate.sv
module clkpm_pair_gate (
    input  logic clk,
    input  logic rst,
    input  logic want,
    input  logic clk_low,
    output logic run
);
    // updates only in the low phase so the pair never emits a runt pulse
    always_ff @(posedge clk) begin
        if (rst)          run <= 1'b0;
        else if (clk_low) run <= want;
    end
endmodule

// File: rtl/clkout_pm_ctrl.sv
module clkout_pm_ctrl
    import clkpm_pkg::*;
#(
    parameter int NPAIR = NUM_PAIRS,
    parameter int SDEP  = SYNC_DEPTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwr_good,
    input  logic [NPAIR-1:0] oe_n,
    input  logic [NPAIR-1:0] oe_reg,
    input  logic             wol_en,
    input  logic             addr_strap,
    input  logic [1:0]       spread_strap,
    input  logic             pll_locked,
    input  logic             dif_clk_low,
    output logic [NPAIR-1:0] dif_run,
    output logic             ref_oe,
    output logic             ref_run,
    output logic [6:0]       smb_addr,
    output logic [1:0]       spread_mode
);
    localparam int SYNC_W = NPAIR + 1;

    logic [SYNC_W-1:0] sync_q;
    logic              pg_sync;
    logic [NPAIR-1:0]  oe_n_sync;
    logic              started;
    strap_cfg_t        cfg;

    clkpm_sync #(.W(SYNC_W), .DEPTH(SDEP)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({pwr_good, oe_n}),
        .q   (sync_q)
    );
    assign pg_sync   = sync_q[SYNC_W-1];
    assign oe_n_sync = sync_q[NPAIR-1:0];

    clkpm_strap_latch u_strap (
        .clk          (clk),
        .rst          (rst),
        .pg_sync      (pg_sync),
        .addr_strap   (addr_strap),
        .spread_strap (spread_strap),
        .started      (started),
        .cfg          (cfg)
    );

    logic pair_common;
    assign pair_common = pg_sync && pll_locked;

    for (genvar g = 0; g < NPAIR; g++) begin : g_pair
        clkpm_pair_gate u_gate (
            .clk     (clk),
            .rst     (rst),
            .want    (pair_common && oe_reg[g] && !oe_n_sync[g]),
            .clk_low (dif_clk_low),
            .run     (dif_run[g])
        );
    end

    assign ref_oe      = started;
    assign ref_run     = started && (pg_sync || wol_en);
    assign smb_addr    = cfg.addr;
    assign spread_mode = cfg.spread;
endmodule

// File: rtl/clkout_pm_ctrl_chk.sv
module clkout_pm_ctrl_chk #(
    parameter int NPAIR = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             pg_sync,
    input logic             pll_locked,
    input logic             dif_clk_low,
    input logic [NPAIR-1:0] dif_run,
    input logic             ref_oe,
    input logic             ref_run,
    input logic [6:0]       smb_addr,
    input logic [1:0]       spread_mode
);
    // R5
    pd_blocks_pairs_chk: assert property (@(posedge clk) disable iff (rst)
        (!pg_sync && dif_clk_low) |=> (dif_run == '0));

    // R9
    unlocked_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        (!pll_locked && dif_clk_low) |=> (dif_run == '0));

    // R10
    high_phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !dif_clk_low |=> $stable(dif_run));

    // R7
    ref_drive_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ref_oe |=> ref_oe);

    // R2
    strap_held_chk: assert property (@(posedge clk) disable iff (rst)
        ref_oe |=> ($stable(smb_addr) && $stable(spread_mode)));

    // R8
    ref_quiet_before_start_chk: assert property (@(posedge clk) disable iff (rst)
        !ref_oe |-> !ref_run);
endmodule

bind clkout_pm_ctrl clkout_pm_ctrl_chk #(.NPAIR(NPAIR)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pg_sync     (pg_sync),
    .pll_locked  (pll_locked),
    .dif_clk_low (dif_clk_low),
    .dif_run     (dif_run),
    .ref_oe      (ref_oe),
    .ref_run     (ref_run),
    .smb_addr    (smb_addr),
    .spread_mode (spread_mode)
);

// File: tb/clkout_pm_ctrl_bench.sv
`timescale 1ns/1ps
module clkout_pm_ctrl_bench;
    localparam int NP = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pwr_good = 1'b0;
    logic [NP-1:0] oe_n = '0;
    logic [NP-1:0] oe_reg = '0;
    logic          wol_en = 1'b0;
    logic          addr_strap = 1'b0;
    logic [1:0]    spread_strap = 2'b00;
    logic          pll_locked = 1'b0;
    logic          dif_clk_low = 1'b1;
    logic [NP-1:0] dif_run;
    logic          ref_oe, ref_run;
    logic [6:0]    smb_addr;
    logic [1:0]    spread_mode;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    clkout_pm_ctrl u_clkout_pm_ctrl (
        .clk(clk), .rst(rst), .pwr_good(pwr_good), .oe_n(oe_n), .oe_reg(oe_reg),
        .wol_en(wol_en), .addr_strap(addr_strap), .spread_strap(spread_strap),
        .pll_locked(pll_locked), .dif_clk_low(dif_clk_low), .dif_run(dif_run),
        .ref_oe(ref_oe), .ref_run(ref_run), .smb_addr(smb_addr), .spread_mode(spread_mode)
    );

    // behavioural reference model
    logic [NP-1:0] m_run = '0;
    logic          m_started = 1'b0;
    logic [6:0]    m_addr = '0;
    logic [1:0]    m_spr = '0;
    logic          m_pgs = 1'b0;
    logic [NP-1:0] m_oes = '0;
    logic          pgq [$];
    logic [NP-1:0] oeq [$];

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_run = '0; m_started = 0; m_addr = '0; m_spr = '0;
            m_pgs = 0; m_oes = '0;
            pgq = {1'b0}; oeq = {{NP{1'b0}}};
        end else begin
            for (int i = 0; i < NP; i++)
                if (dif_clk_low)
                    m_run[i] = m_pgs && pll_locked && oe_reg[i] && !m_oes[i];
            if (m_pgs && !m_started) begin
                m_started = 1;
                m_addr = addr_strap ? 7'h6A : 7'h68;
                m_spr  = (spread_strap == 2'b11) ? 2'b00 : spread_strap;
            end
            pgq.push_back(pwr_good); m_pgs = pgq.pop_front();
            oeq.push_back(oe_n);     m_oes = oeq.pop_front();
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cycles > 0) begin
            chk("R6 dif_run vs model", 32'(dif_run), 32'(m_run));
            chk("R7 ref_oe vs model", 32'(ref_oe), 32'(m_started));
            chk("R8 ref_run vs model", 32'(ref_run), 32'(m_started && (m_pgs || wol_en)));
            chk("R3 smb_addr vs model", 32'(smb_addr), 32'(m_addr));
            chk("R4 spread_mode vs model", 32'(spread_mode), 32'(m_spr));
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic startup(input logic a, input logic [1:0] s, input logic [6:0] ea, input logic [1:0] es);
        rst = 1; pwr_good = 0; pll_locked = 0; addr_strap = a; spread_strap = s;
        cyc(3);
        chk("R1 reset dif_run", 32'(dif_run), 0);
        chk("R1 reset ref", 32'({ref_oe, ref_run}), 0);
        chk("R1 reset cfg", 32'({smb_addr, spread_mode}), 0);
        rst = 0; pwr_good = 1;
        cyc(2);
        chk("R7 ref hi-Z before start", 32'(ref_oe), 0);
        cyc(1);
        chk("R7 ref driven at start", 32'(ref_oe), 1);
        chk("R3 address capture", 32'(smb_addr), 32'(ea));
        chk("R4 spread capture", 32'(spread_mode), 32'(es));
    endtask

    initial begin
        oe_reg = '1; oe_n = '0; dif_clk_low = 1;
        startup(1'b1, 2'b10, 7'h6A, 2'b10);
        chk("R9 unlocked blocks", 32'(dif_run), 0);
        pll_locked = 1;
        cyc(1);
        chk("R6 all pairs run", 32'(dif_run), 32'h3F);
        chk("R8 ref runs", 32'(ref_run), 1);

        // R2: new strap levels and a power cycle must not re-capture
        addr_strap = 0; spread_strap = 2'b01;
        pwr_good = 0;
        cyc(4);
        chk("R5 power-down blocks pairs", 32'(dif_run), 0);
        chk("R8 ref low in power-down", 32'(ref_run), 0);
        chk("R7 ref still driven", 32'(ref_oe), 1);
        wol_en = 1;
        cyc(1);
        chk("R8 wake-on-LAN keeps ref", 32'(ref_run), 1);
        pwr_good = 1; wol_en = 0;
        cyc(4);
        chk("R2 address not resampled", 32'(smb_addr), 32'h6A);
        chk("R2 spread not resampled", 32'(spread_mode), 2'b10);
        chk("R6 pairs back after exit", 32'(dif_run), 32'h3F);

        // R11: two-flop latency on oe_n
        oe_n[2] = 1;
        cyc(2);
        chk("R11 pair 2 still running", 32'(dif_run[2]), 1);
        cyc(1);
        chk("R11 pair 2 stopped", 32'(dif_run[2]), 0);

        // R10: no change while the gated clock is high
        dif_clk_low = 0; oe_reg[0] = 0;
        cyc(3);
        chk("R10 hold while high", 32'(dif_run[0]), 1);
        dif_clk_low = 1;
        cyc(1);
        chk("R10 update in low phase", 32'(dif_run[0]), 0);

        // mixed patterns compared against the model
        begin
            logic [15:0] lf = 16'hACE1;
            for (int k = 0; k < 400; k++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                oe_n = lf[5:0]; oe_reg = lf[11:6] | 6'h21;
                wol_en = lf[12]; pll_locked = lf[13] | lf[1];
                dif_clk_low = lf[14] | lf[3];
                addr_strap = lf[15]; spread_strap = lf[9:8];
                if ((k % 23) == 0) pwr_good = ~pwr_good;
                cyc(1);
            end
        end

        oe_reg = '1; oe_n = '0; dif_clk_low = 1; wol_en = 0;
        startup(1'b0, 2'b11, 7'h68, 2'b00);
        startup(1'b0, 2'b01, 7'h68, 2'b01);
        startup(1'b1, 2'b00, 7'h6A, 2'b00);
        cyc(2);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        checks++; errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule